// File: doc/BRIEF.md
# Debug Event Status Register with Mask-Clear Writes

This block holds a 32-bit record of debug events. Event sources inside the core raise one-cycle strobes, and each strobe makes its status bit 1. The bit then stays 1 until software clears it. Software never writes data into the register. A software write carries a clear mask: every 1 in the mask clears the bit in that position, and every 0 leaves that bit as it was.

Two bits at the top of the register have a fixed meaning. Bit 31 is the imprecise flag. Hardware sets it when any event strobe fires while the debug-enable input is low, which means an event was logged while debug interrupts could not be taken. Bit 30 is the unconditional-event bit, and its own strobe sets it. The read port returns the register zero-extended to 64 bits. The read path is combinational, so it always shows the current register contents.

Top module: `dbg_status_reg`

## Requirements
- R1: After reset is asserted (rst_n low), all 32 status bits read 0.
- R2: A 1 on evt_set_i[k], for k from 0 to 30, makes status bit k equal to 1 at the next rising clock edge. The bit keeps that value for as long as no software clear targets it.
- R3: A write (wr_en_i high) clears, at the next clock edge, every status bit whose position holds a 1 in wr_mask_i. Every bit whose mask position holds a 0 keeps its value.
- R4: While wr_en_i is low, wr_mask_i has no effect on any status bit.
- R5: When a set and a write clear target the same bit in the same cycle, the bit is 1 after the edge. This applies to the imprecise flag as well.
- R6: Status bit 31, the imprecise flag, becomes 1 at the next edge whenever at least one evt_set_i bit is 1 while dbg_en_i is 0. An event strobe taken while dbg_en_i is 1 leaves bit 31 unchanged.
- R7: Status bit 30, the unconditional-event bit, is set by evt_set_i[30]. When dbg_en_i is 0, that event also sets bit 31.
- R8: rd_data_o[31:0] equals the current status register in the same cycle, and rd_data_o[63:32] is always 0.
- R9: Setting or holding the imprecise flag is not itself an event. With no event strobes, bit 31 never sets itself, and it never sets any other bit, whatever the value of dbg_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set_i | input | 31 | Per-bit hardware set strobes for status bits 30..0 |
| dbg_en_i | input | 1 | High when debug interrupts are enabled |
| wr_en_i | input | 1 | Software write strobe |
| wr_mask_i | input | 32 | Clear mask; a 1 clears the bit in that position |
| rd_data_o | output | 64 | Status register, zero-extended to 64 bits |

## Verification
The bench places a set and a clear on the same bit in the same cycle, for an ordinary bit and for the imprecise flag. A design that lets the clear win would drop a freshly logged event. It also presents a full clear mask while the write strobe is low, which a design that ignores the strobe would use to wipe the register. Event strobes are given with debug enabled and with debug disabled, to catch an imprecise flag that is tied to the wrong condition. After bit 31 is cleared, the bench idles with debug disabled, which exposes a flag that sets itself again. The upper half of the read word is checked on every read, to catch sign-extension or replication of the status bits.

// File: rtl/dstat_pkg.sv
package dstat_pkg;
    localparam int DEF_STAT_W = 32;
    localparam int DEF_RD_W   = 64;

    // Position of the imprecise flag: the top bit of the register
    function automatic int imp_pos(input int w);
        return w - 1;
    endfunction

    // Position of the unconditional-event bit: just below the imprecise flag
    function automatic int unc_pos(input int w);
        return w - 2;
    endfunction
endpackage

// File: rtl/dstat_evt_merge.sv
module dstat_evt_merge
    import dstat_pkg::*;
#(
    parameter int STAT_W = DEF_STAT_W
) (
    input  logic [STAT_W-2:0] evt_set_i,
    input  logic              dbg_en_i,
    output logic [STAT_W-1:0] set_vec_o
);
    localparam int EVT_W = STAT_W - 1;
    localparam int IMP   = imp_pos(STAT_W);

    // Hardware-sourced bits map one to one onto their strobes
    for (genvar k = 0; k < EVT_W; k++) begin : g_evt
        assign set_vec_o[k] = evt_set_i[k];
    end

    // The imprecise flag comes only from real event strobes, never from itself
    assign set_vec_o[IMP] = (|evt_set_i) & ~dbg_en_i;
endmodule

// File: rtl/dstat_core.sv
module dstat_core
    import dstat_pkg::*;
#(
    parameter int STAT_W = DEF_STAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_vec_i,
    input  logic              wr_en_i,
    input  logic [STAT_W-1:0] wr_mask_i,
    output logic [STAT_W-1:0] stat_o
);
    typedef struct packed {
        logic [STAT_W-1:0] stat;
    } state_t;

    state_t            st_d, st_q;
    logic [STAT_W-1:0] clr_d;

    always_comb begin
        st_d  = st_q;
        clr_d = wr_en_i ? wr_mask_i : '0;
        // Clear first, then set, so a same-cycle set wins
        st_d.stat = (st_q.stat & ~clr_d) | set_vec_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;

    // R2 / R5: every requested set is visible after the edge, clear or not
    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & $past(set_vec_i)) == $past(set_vec_i)));

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_mask_i & set_vec_i) != '0)
        |=> ((stat_o & $past(wr_mask_i & set_vec_i)) == $past(wr_mask_i & set_vec_i)));

    // R3: masked bits without a competing set are 0 after a write
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> ((stat_o & $past(wr_mask_i & ~set_vec_i)) == '0));

    // R4: with no write, no bit can fall
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));
endmodule

// File: rtl/dstat_rdext.sv
module dstat_rdext
    import dstat_pkg::*;
#(
    parameter int STAT_W = DEF_STAT_W,
    parameter int RD_W   = DEF_RD_W
) (
    input  logic [STAT_W-1:0] stat_i,
    output logic [RD_W-1:0]   rd_o
);
    for (genvar i = 0; i < RD_W; i++) begin : g_ext
        if (i < STAT_W) begin : g_bit
            assign rd_o[i] = stat_i[i];
        end else begin : g_zero
            assign rd_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg
    import dstat_pkg::*;
#(
    parameter int STAT_W = DEF_STAT_W,
    parameter int RD_W   = DEF_RD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-2:0] evt_set_i,
    input  logic              dbg_en_i,
    input  logic              wr_en_i,
    input  logic [STAT_W-1:0] wr_mask_i,
    output logic [RD_W-1:0]   rd_data_o
);
    localparam int IMP = imp_pos(STAT_W);
    localparam int UNC = unc_pos(STAT_W);

    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] stat;

    dstat_evt_merge #(.STAT_W(STAT_W)) u_merge (
        .evt_set_i (evt_set_i),
        .dbg_en_i  (dbg_en_i),
        .set_vec_o (set_vec)
    );

    dstat_core #(.STAT_W(STAT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec_i (set_vec),
        .wr_en_i   (wr_en_i),
        .wr_mask_i (wr_mask_i),
        .stat_o    (stat)
    );

    dstat_rdext #(.STAT_W(STAT_W), .RD_W(RD_W)) u_rd (
        .stat_i (stat),
        .rd_o   (rd_data_o)
    );

    // R6: an event taken with debug disabled raises the imprecise flag
    p_imp_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|evt_set_i) && !dbg_en_i) |=> rd_data_o[IMP]);

    // R7: the unconditional strobe lands in its own bit
    p_unc_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_set_i[UNC] |=> rd_data_o[UNC]);

    // R9: with no strobes, a cleared imprecise flag stays cleared
    p_imp_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data_o[IMP] && evt_set_i == '0) |=> !rd_data_o[IMP]);

    // R8: upper half of the read word is always zero
    always_comb begin
        if (rst_n) begin
            p_rd_upper_r8: assert (rd_data_o[RD_W-1:STAT_W] == '0);
        end
    end
endmodule

// File: tb/dbg_status_reg_tb.sv
module dbg_status_reg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [30:0] evt_set = '0;
    logic        dbg_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_mask = '0;
    logic [63:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dbg_status_reg u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_set_i (evt_set),
        .dbg_en_i  (dbg_en),
        .wr_en_i   (wr_en),
        .wr_mask_i (wr_mask),
        .rd_data_o (rd_data)
    );

    task automatic check(input string req, input logic [63:0] exp);
        n_tests++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, rd_data, exp);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge; return at the next falling edge
    task automatic cycle(input logic [30:0] ev, input logic en,
                         input logic we, input logic [31:0] msk);
        evt_set = ev; dbg_en = en; wr_en = we; wr_mask = msk;
        @(negedge clk);
        evt_set = '0; dbg_en = 1'b1; wr_en = 1'b0; wr_mask = '0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset value", 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 read after reset", 64'h0);
    endtask

    task automatic t_set_each;
        logic [31:0] exp = '0;
        for (int k = 0; k < 31; k++) begin
            cycle(31'(1) << k, 1'b1, 1'b0, '0);
            exp[k] = 1'b1;
            check("R2 per-bit set", {32'h0, exp});
        end
        // R6 negative: debug enabled, so bit 31 stays 0; R7 bit 30 came from its strobe
        check("R6 no imprecise while enabled", 64'h0000_0000_7FFF_FFFF);
        cycle('0, 1'b1, 1'b0, '0);
        check("R2 sticky", 64'h0000_0000_7FFF_FFFF);
    endtask

    task automatic t_clear_mask;
        cycle('0, 1'b1, 1'b1, 32'h0000_FFFF);
        check("R3 partial clear", 64'h0000_0000_7FFF_0000);
        cycle('0, 1'b1, 1'b1, 32'hA5A5_0000);
        check("R3 pattern clear", 64'h0000_0000_5A5A_0000);
    endtask

    task automatic t_ignore_mask;
        cycle('0, 1'b1, 1'b0, 32'hFFFF_FFFF);
        check("R4 mask without strobe", 64'h0000_0000_5A5A_0000);
        cycle('0, 1'b1, 1'b1, 32'hFFFF_FFFF);
        check("R3 full clear", 64'h0);
    endtask

    task automatic t_imprecise;
        cycle(31'h0000_0008, 1'b0, 1'b0, '0);
        check("R6 imprecise set", 64'h0000_0000_8000_0008);
        cycle('0, 1'b0, 1'b1, 32'h0000_0008);
        check("R9 flag keeps, nothing else set", 64'h0000_0000_8000_0000);
        cycle('0, 1'b0, 1'b1, 32'h8000_0000);
        check("R3 clear imprecise", 64'h0);
        for (int i = 0; i < 3; i++) cycle('0, 1'b0, 1'b0, '0);
        check("R9 no self set", 64'h0);
    endtask

    task automatic t_unconditional;
        cycle(31'h4000_0000, 1'b0, 1'b0, '0);
        check("R7 unconditional with imprecise", 64'h0000_0000_C000_0000);
        cycle('0, 1'b1, 1'b1, 32'hFFFF_FFFF);
        cycle(31'h4000_0000, 1'b1, 1'b0, '0);
        check("R7 unconditional alone", 64'h0000_0000_4000_0000);
    endtask

    task automatic t_set_wins;
        cycle(31'h0000_0020, 1'b1, 1'b0, '0);
        check("R2 setup bit 5", 64'h0000_0000_4000_0020);
        cycle(31'h0000_0020, 1'b1, 1'b1, 32'hFFFF_FFFF);
        check("R5 set beats clear", 64'h0000_0000_0000_0020);
        cycle(31'h0000_0001, 1'b0, 1'b1, 32'h8000_0021);
        check("R5 imprecise set beats clear", 64'h0000_0000_8000_0001);
    endtask

    initial begin
        repeat (5000) @(negedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_set_each();
        t_clear_mask();
        t_ignore_mask();
        t_imprecise();
        t_unconditional();
        t_set_wins();
        t_reset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule